// File: doc/BRIEF.md
# Pin Change Interrupt with Read-Reloaded Shadow

This block watches an eight-bit port and raises a level interrupt when any watched input pin holds a value that differs from a stored snapshot of the port. The snapshot is not the value the pins had on the previous clock. It is refreshed only when software reads the port status. A key-matrix or wake-up pin therefore keeps the interrupt raised until software has seen the change.

A pin is watched only when its direction bit marks it as an input and its per-pin mode bit is set. Each status read does three things at once. It captures the current pin values as the status word that software sees. It copies the same values into the snapshot. It clears the interrupt. After the read, detection is armed again against the new snapshot.

Software is expected to read the status once before it enables any pin. This gives the snapshot a known value. The pin inputs are assumed to be synchronized already.

Top module: `pin_change_irq`

## Requirements
- R1: After a synchronous reset, the snapshot (`snap_o`), the status word (`status_o`) and `irq_o` are all zero.
- R2: A pin takes part in detection only when its direction bit is 0 (input) and its mode bit is 1. A mismatch on a pin with direction 1, or with mode 0, never sets `irq_o`.
- R3: On each clock edge where `rd_stb_i` is 1, `snap_o` takes the value of `pin_i`. On every other edge, `snap_o` keeps its value.
- R4: If a watched pin differs from its snapshot bit at a clock edge with no read, `irq_o` is 1 after that edge.
- R5: `irq_o` is 0 after every clock edge where `rd_stb_i` is 1.
- R6: `irq_o` stays 1 for as long as the mismatch remains. It returns to 0 one edge after the pin goes back to its snapshot value.
- R7: On a read edge, `status_o` captures `pin_i`. It holds that value until the next read.
- R8: If a pin changes in the same cycle as a read, both the snapshot and the status word take the new value. No interrupt follows for that change.
- R9: After a read, a new mismatch on a watched pin raises `irq_o` again on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 8 | Synchronized pin values |
| dir_i | input | 8 | Per-pin direction, 1 = output, 0 = input |
| mode_i | input | 8 | Per-pin mode bit; on input pins, 1 enables watching |
| rd_stb_i | input | 1 | Status-read strobe, one cycle per read |
| irq_o | output | 1 | Level interrupt, registered |
| snap_o | output | 8 | Snapshot register, for debug |
| status_o | output | 8 | Pin values captured at the last read |

## Verification
The vector table pairs direction and mode patterns with pin changes, so that each pattern separates one case from the others:
- all pins watched;
- output pins that change;
- input pins that change with mode 0;
- a single watched bit inside an otherwise masked byte;
- a change on a watched pin whose value did not differ from the snapshot.

Directed sequences then check three things:
- the interrupt holds while a mismatch persists, and falls when the pin returns to its snapshot value;
- a pin that changes in the same cycle as the read is absorbed into the snapshot;
- a fresh change after a read raises the interrupt again.

// File: rtl/pcint_pkg.sv
package pcint_pkg;

    localparam int PCINT_W = 8;

    typedef enum logic [1:0] {
        ROLE_DRIVE = 2'd0,
        ROLE_QUIET = 2'd1,
        ROLE_WATCH = 2'd2
    } pin_role_e;

    function automatic pin_role_e classify(input logic dir, input logic mode);
        if (dir)
            return ROLE_DRIVE;
        else if (mode)
            return ROLE_WATCH;
        else
            return ROLE_QUIET;
    endfunction

endpackage

// File: rtl/pcint_enable.sv
module pcint_enable
    import pcint_pkg::*;
#(
    parameter int W = PCINT_W
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mode_i,
    output logic [W-1:0] watch_o
);

    for (genvar g = 0; g < W; g++) begin : g_pin
        pin_role_e role;
        assign role       = classify(dir_i[g], mode_i[g]);
        assign watch_o[g] = (role == ROLE_WATCH);
    end

endmodule

// File: rtl/pcint_shadow.sv
module pcint_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_stb_i,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] snap_o,
    output logic [W-1:0] status_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_o   <= '0;
            status_o <= '0;
        end else if (rd_stb_i) begin
            snap_o   <= pin_i;
            status_o <= pin_i;
        end
    end

    // R3
    snap_load_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb_i |=> snap_o == $past(pin_i));

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> $stable(snap_o));

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> $stable(status_o));

endmodule

// File: rtl/pcint_detect.sv
module pcint_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_stb_i,
    input  logic [W-1:0] watch_i,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] snap_i,
    output logic         irq_o
);

    logic [W-1:0] diff;
    logic         hit;

    assign diff = watch_i & (pin_i ^ snap_i);
    assign hit  = |diff;

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else if (rd_stb_i)
            irq_o <= 1'b0;
        else
            irq_o <= hit;
    end

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb_i |=> !irq_o);

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (watch_i == '0) |=> !irq_o);

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcint_pkg::*;
#(
    parameter int W = PCINT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mode_i,
    input  logic         rd_stb_i,
    output logic         irq_o,
    output logic [W-1:0] snap_o,
    output logic [W-1:0] status_o
);

    logic [W-1:0] watch;

    pcint_enable #(.W(W)) u_enable (
        .dir_i   (dir_i),
        .mode_i  (mode_i),
        .watch_o (watch)
    );

    pcint_shadow #(.W(W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .rd_stb_i (rd_stb_i),
        .pin_i    (pin_i),
        .snap_o   (snap_o),
        .status_o (status_o)
    );

    pcint_detect #(.W(W)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .rd_stb_i (rd_stb_i),
        .watch_i  (watch),
        .pin_i    (pin_i),
        .snap_i   (snap_o),
        .irq_o    (irq_o)
    );

    // R4
    raise_on_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb_i && ((~dir_i & mode_i & (pin_i ^ snap_o)) != '0)) |=> irq_o);

endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin = '0;
    logic [7:0] dir = '0;
    logic [7:0] mode = '0;
    logic       rd = 1'b0;
    logic       irq;
    logic [7:0] snap;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pin_change_irq u_dut (
        .clk(clk), .rst(rst), .pin_i(pin), .dir_i(dir), .mode_i(mode),
        .rd_stb_i(rd), .irq_o(irq), .snap_o(snap), .status_o(status)
    );

    // {dir, mode, pin before read, pin after read}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'h00, 8'h01},
        {8'hFF, 8'hFF, 8'h00, 8'hFF},
        {8'h00, 8'h00, 8'h55, 8'hAA},
        {8'h00, 8'h10, 8'hEF, 8'h00},
        {8'h00, 8'h10, 8'h00, 8'h10},
        {8'hF0, 8'hFF, 8'h0F, 8'hF3},
        {8'h00, 8'hFF, 8'hA5, 8'hA5},
        {8'h0F, 8'hF0, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 snap", snap, 8'h00);
        check("R1 status", status, 8'h00);
        rst = 1'b0;
        do_read();

        for (int i = 0; i < NV; i++) begin
            logic [7:0] d, m, a, b, e;
            {d, m, a, b} = VEC[i];
            dir = d; mode = m; pin = a;
            do_read();
            // R3 and R7: the snapshot and the status word hold the value read
            check("R3 snap after read", snap, a);
            check("R7 status after read", status, a);
            // R5: the read clears the interrupt
            check("R5 irq after read", {7'b0, irq}, 8'h00);
            pin = b;
            e = {7'b0, |(~d & m & (a ^ b))};
            @(negedge clk);
            // R2 and R4: only watched pins that changed raise the interrupt
            check("R2/R4 irq vector", {7'b0, irq}, e);
        end

        // R6: the interrupt persists, then falls when the pin returns
        dir = 8'h00; mode = 8'h01; pin = 8'h00;
        do_read();
        pin = 8'h01;
        repeat (4) @(negedge clk);
        check("R6 irq persists", {7'b0, irq}, 8'h01);
        check("R6 snap unchanged", snap, 8'h00);
        pin = 8'h00;
        @(negedge clk);
        check("R6 irq falls on return", {7'b0, irq}, 8'h00);

        // R8: a pin change in the same cycle as the read is absorbed
        @(negedge clk); rd = 1'b1; pin = 8'h01;
        @(negedge clk); rd = 1'b0;
        check("R8 snap new", snap, 8'h01);
        check("R8 status new", status, 8'h01);
        @(negedge clk);
        check("R8 no irq", {7'b0, irq}, 8'h00);

        // R9: a new change after the read raises the interrupt again
        pin = 8'h00;
        @(negedge clk);
        check("R9 re-raise", {7'b0, irq}, 8'h01);
        do_read();
        check("R9 cleared", {7'b0, irq}, 8'h00);
        check("R7 status latest", status, 8'h00);

        // R1: reset in the middle of operation
        pin = 8'h01;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        check("R1 reset snap", snap, 8'h00);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule